// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that has an 18-bit write port and an 18-bit read port. Each port runs on its own clock. The depth is a power-of-two parameter between 256 and 4096 words. A word is stored on every write-clock edge where the write enable is high. A word is moved into the output register on every read-clock edge where the read enable is high. The two clocks may be the same net or may be unrelated. The read and write pointers cross between the two domains as Gray code through two-flop synchronizers. Empty and almost-empty are judged on the read side. Full, almost-full and half-full are judged on the write side.

Two offsets set the almost-empty and almost-full thresholds. Both offsets take the value 7 at reset. Software can change them by holding the `load` input high and giving write-enabled clocks. The first such clock writes the almost-empty offset, the next writes the almost-full offset, and the sequence then wraps. The offset is taken from the low bits of the write data. The read data bus goes high-impedance whenever the output enable is low.

The reset input is synchronous and active high. It must be held for several edges of both clocks. Reset empties the buffer, sets Empty and restores both offsets to their default.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words are delivered on the read port in the order they were written. A read-clock edge with `rd_en` high while not empty places the oldest word in the output register, and the word is visible after that edge.
- R2: `empty` is high after reset. It goes low within a few read-clock edges after a write. It returns high once the last stored word has been read.
- R3: `full` is high when DEPTH words are stored. A write attempted while `full` is high is dropped. Such a write changes neither the stored words nor the word count.
- R4: A read attempted while `empty` is high is ignored. `rd_data` keeps its value, and the next word written is the next word read.
- R5: `almost_empty` is high exactly when the read-side word count is less than or equal to the almost-empty offset.
- R6: `almost_full` is high exactly when the write-side word count is greater than or equal to DEPTH minus the almost-full offset.
- R7: `half_full` is high exactly when the write-side word count is greater than DEPTH/2.
- R8: After reset both offsets equal 7, whatever values were loaded before the reset.
- R9: While `load` is high, each write-clock edge with `wr_en` high writes `wr_data[ADDR_W-1:0]` into an offset, where ADDR_W = log2(DEPTH). The first such edge writes the almost-empty offset, the second writes the almost-full offset, and the sequence then repeats. The sequence restarts at the almost-empty offset whenever `load` goes low. No FIFO data is stored while `load` is high.
- R10: When `out_en` is low, `rd_data` is high-impedance and the stored word does not appear on it. Raising `out_en` shows the output register unchanged.
- R11: R1 to R7 hold both when the read clock is the write clock and when the read clock runs at an unrelated frequency.
- R12: Reset clears both pointers. After reset `empty` and `almost_empty` are high, and `full`, `half_full` and `almost_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| wr_en | input | 1 | Store a word (or an offset when `load` is high) |
| wr_data | input | 18 | Write data; the low ADDR_W bits carry offsets during loading |
| load | input | 1 | Route write-enabled clocks to the offset sequencer |
| rd_en | input | 1 | Advance the output register to the next word |
| out_en | input | 1 | Drive `rd_data` when high, high-impedance when low |
| rd_data | output | 18 | Registered read data |
| empty | output | 1 | No word stored (read domain) |
| almost_empty | output | 1 | Count at or below the almost-empty offset (read domain) |
| half_full | output | 1 | Count above DEPTH/2 (write domain) |
| almost_full | output | 1 | Count at or above DEPTH minus the almost-full offset (write domain) |
| full | output | 1 | DEPTH words stored (write domain) |

## Verification
The bench sets up the count on both sides of every flag threshold: 7/8 for almost-empty, 128/129 for half-full, 248/249 for almost-full, and 255/256 for full. A comparison that is off by one, for example greater-than in place of greater-or-equal, therefore flips one flag at one step. It writes past full and reads past empty. A design that moved a pointer anyway would, after the buffer is drained, show a stray word, a repeated word, or a wrong empty state. The offset sequencer is tested with a third loaded value that must wrap back to almost-empty, and with a restart after `load` drops. It is also tested by a reset that must discard loaded offsets. A sequencer that lost its place, leaked writes into the buffer or kept offsets across reset would show a wrong flag. The whole table runs a second time with an unrelated read clock, so that pointer-crossing faults appear as wrong data or flags.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  // Supported depth range of the buffer
  localparam int DEPTH_MIN = 256;
  localparam int DEPTH_MAX = 4096;

  // Which offset the next load-mode write targets
  typedef enum logic {
    SEL_EMPTY_OFF = 1'b0,
    SEL_FULL_OFF  = 1'b1
  } off_sel_e;
endpackage

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  // Simple dual-port: one write port, one registered read port
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              load,
  input  logic [ADDR_W-1:0] cfg_val,
  input  logic [PTR_W-1:0]  rd_gray_s,
  output logic              push,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTR_W-1:0]  wr_gray,
  output logic              full,
  output logic              almost_full,
  output logic              half_full,
  output logic [ADDR_W-1:0] ae_off,
  output logic [ADDR_W-1:0] af_off
);
  localparam logic [PTR_W-1:0]  DEPTH_P = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0]  HALF_P  = PTR_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] OFF_RST = ADDR_W'(DEF_OFF);

  logic [PTR_W-1:0] wr_bin, wr_bin_nxt, rd_bin_s, wcount, af_limit;
  off_sel_e         sel;

  // Gray to binary of the synchronized read pointer
  for (genvar i = 0; i < PTR_W; i++) begin : g_rd_g2b
    assign rd_bin_s[i] = ^rd_gray_s[PTR_W-1:i];
  end

  assign push       = wr_en && !load && !full;
  assign wr_bin_nxt = wr_bin + {{(PTR_W-1){1'b0}}, push};
  assign wr_addr    = wr_bin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else begin
      wr_bin  <= wr_bin_nxt;
      wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
    end
  end

  // Occupancy as seen from the write side (pessimistic: reads lag)
  assign wcount      = wr_bin - rd_bin_s;
  assign af_limit    = DEPTH_P - {1'b0, af_off};
  assign full        = (wcount == DEPTH_P);
  assign almost_full = (wcount >= af_limit);
  assign half_full   = (wcount > HALF_P);

  // Offset sequencer: alternates targets while load stays high
  always_ff @(posedge clk) begin
    if (rst) begin
      ae_off <= OFF_RST;
      af_off <= OFF_RST;
      sel    <= SEL_EMPTY_OFF;
    end else if (load) begin
      if (wr_en) begin
        if (sel == SEL_EMPTY_OFF) begin
          ae_off <= cfg_val;
          sel    <= SEL_FULL_OFF;
        end else begin
          af_off <= cfg_val;
          sel    <= SEL_EMPTY_OFF;
        end
      end
    end else begin
      sel <= SEL_EMPTY_OFF;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> $stable(wr_bin));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    wcount <= DEPTH_P);

  assert_load_blocks_data_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> $stable(wr_bin));

  assert_full_is_almost_full_R6: assert property (@(posedge clk) disable iff (rst)
    full |-> (almost_full && half_full));
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl #(
  parameter int DEPTH   = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  wr_gray_s,
  input  logic [ADDR_W-1:0] ae_off,
  output logic              pop,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rd_gray,
  output logic              empty,
  output logic              almost_empty
);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [PTR_W-1:0] rd_bin, rd_bin_nxt, wr_bin_s, rcount;

  for (genvar i = 0; i < PTR_W; i++) begin : g_wr_g2b
    assign wr_bin_s[i] = ^wr_gray_s[PTR_W-1:i];
  end

  assign pop        = rd_en && !empty;
  assign rd_bin_nxt = rd_bin + {{(PTR_W-1){1'b0}}, pop};
  assign rd_addr    = rd_bin[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else begin
      rd_bin  <= rd_bin_nxt;
      rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
    end
  end

  // Occupancy as seen from the read side (pessimistic: writes lag)
  assign rcount       = wr_bin_s - rd_bin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= {1'b0, ae_off});

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> $stable(rd_bin));

  assert_rd_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    rcount <= DEPTH_P);

  assert_empty_is_almost_empty_R5: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DATA_W  = 18,
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              rd_en,
  input  logic              out_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              half_full,
  output logic              almost_full,
  output logic              full
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic              push, pop;
  logic [ADDR_W-1:0] wr_addr, rd_addr, ae_off, af_off;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [DATA_W-1:0] rd_q;

  dcfifo_wr_ctrl #(.DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .clk         (wr_clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .load        (load),
    .cfg_val     (wr_data[ADDR_W-1:0]),
    .rd_gray_s   (rd_gray_s),
    .push        (push),
    .wr_addr     (wr_addr),
    .wr_gray     (wr_gray),
    .full        (full),
    .almost_full (almost_full),
    .half_full   (half_full),
    .ae_off      (ae_off),
    .af_off      (af_off)
  );

  dcfifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk          (rd_clk),
    .rst          (rst),
    .rd_en        (rd_en),
    .wr_gray_s    (wr_gray_s),
    .ae_off       (ae_off),
    .pop          (pop),
    .rd_addr      (rd_addr),
    .rd_gray      (rd_gray),
    .empty        (empty),
    .almost_empty (almost_empty)
  );

  dcfifo_sync #(.W(PTR_W)) u_sync_w2r (
    .clk (rd_clk),
    .rst (rst),
    .d   (wr_gray),
    .q   (wr_gray_s)
  );

  dcfifo_sync #(.W(PTR_W)) u_sync_r2w (
    .clk (wr_clk),
    .rst (rst),
    .d   (rd_gray),
    .q   (rd_gray_s)
  );

  dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk  (wr_clk),
    .wr_en   (push),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_en   (pop),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  assign rd_data = out_en ? rd_q : {DATA_W{1'bz}};

  assert_pop_needs_data_R4: assert property (@(posedge rd_clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
  localparam int DW    = 18;
  localparam int DEPTH = 256;

  // {is_read, word count, expected {empty, almost_empty, half_full, almost_full, full}}
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 10'd0,   5'b11000},
    {1'b0, 10'd7,   5'b01000},
    {1'b0, 10'd1,   5'b00000},
    {1'b0, 10'd120, 5'b00000},
    {1'b0, 10'd1,   5'b00100},
    {1'b0, 10'd119, 5'b00100},
    {1'b0, 10'd1,   5'b00110},
    {1'b0, 10'd7,   5'b00111},
    {1'b1, 10'd1,   5'b00110},
    {1'b1, 10'd247, 5'b00000},
    {1'b1, 10'd1,   5'b01000},
    {1'b1, 10'd7,   5'b11000}
  };

  logic clk_a = 1'b0, clk_b = 1'b0, sel_async = 1'b0;
  logic wr_clk, rd_clk;
  logic rst = 1'b1, wr_en = 1'b0, load = 1'b0, rd_en = 1'b0, out_en = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic empty, almost_empty, half_full, almost_full, full;
  logic [4:0] flg;
  logic [15:0] ent;
  logic [DW-1:0] held;
  int checks = 0, fails = 0, wseq = 0, rseq = 0;
  bit done = 0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;
  assign wr_clk = clk_a;
  assign rd_clk = sel_async ? clk_b : clk_a;
  assign flg = {empty, almost_empty, half_full, almost_full, full};

  dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .DEF_OFF(7)) i_dual_clock_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .load(load), .rd_en(rd_en), .out_en(out_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty), .half_full(half_full),
    .almost_full(almost_full), .full(full));

  function automatic logic [DW-1:0] word_of(int s);
    return DW'((s * 7919 + 3) ^ 18'h15A5A);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1; wr_data = word_of(wseq); wseq++;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_n(input int n, input string req);
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      if (i == n - 1) rd_en = 1'b0;
      chk($sformatf("%s read word %0d", req, rseq), {14'd0, rd_data}, {14'd0, word_of(rseq)});
      rseq++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; load = 1'b0;
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
    @(negedge wr_clk);
    rst = 1'b0;
    rseq = wseq;
    settle();
  endtask

  task automatic load_word(input logic [DW-1:0] v);
    @(negedge wr_clk);
    load = 1'b1; wr_en = 1'b1; wr_data = v;
  endtask

  task automatic load_end();
    @(negedge wr_clk);
    load = 1'b0; wr_en = 1'b0;
  endtask

  task automatic run_table(input string mode);
    for (int k = 0; k < 12; k++) begin
      ent = VEC[k];
      if (ent[15]) pop_n(int'(ent[14:5]), {"R1 ", mode});
      else push_n(int'(ent[14:5]));
      settle();
      chk($sformatf("R2 R5 R6 R7 %s flags step %0d", mode, k), {27'd0, flg}, {27'd0, ent[4:0]});
    end
  endtask

  task automatic overflow_test(input string mode);
    push_n(DEPTH);
    settle();
    chk({"R3 full at depth ", mode}, {31'd0, full}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1; wr_data = 18'h3FFFF ^ DW'(i);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
    settle();
    chk({"R3 full after dropped writes ", mode}, {27'd0, flg}, {27'd0, 5'b00111});
    pop_n(DEPTH, {"R3 drain ", mode});
    settle();
    chk({"R3 empty after drain, no stray words ", mode}, {31'd0, empty}, 32'd1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    do_reset();
    chk("R12 flags after reset", {27'd0, flg}, {27'd0, 5'b11000});

    run_table("tied");
    overflow_test("tied");

    // R4: reads on an empty buffer
    held = rd_data;
    @(negedge rd_clk); rd_en = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en = 1'b0;
    settle();
    chk("R4 rd_data holds on empty read", {14'd0, rd_data}, {14'd0, held});
    chk("R4 still empty", {31'd0, empty}, 32'd1);
    push_n(1);
    settle();
    pop_n(1, "R4 next write is next read");

    // R10: output enable
    push_n(1);
    settle();
    out_en = 1'b0;
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    checks++;
    if (rd_data === word_of(rseq)) begin
      fails++;
      $display("FAIL R10 word visible while disabled actual=%0h expected=%0h", rd_data, 18'bz);
    end
    out_en = 1'b1;
    #1;
    chk("R10 word after enable", {14'd0, rd_data}, {14'd0, word_of(rseq)});
    rseq++;

    // R9: offset sequencer with wrap back to almost-empty offset
    load_word(18'd3); load_word(18'd250); load_word(18'd2); load_end();
    settle();
    push_n(3);
    settle();
    chk("R9 wrap wrote ae=2, af=250, count 3", {27'd0, flg}, {27'd0, 5'b00000});
    push_n(3);
    settle();
    chk("R9 af offset 250 at count 6", {27'd0, flg}, {27'd0, 5'b00010});
    load_word(18'd5); load_end();
    load_word(18'd9); load_end();
    settle();
    chk("R9 restart targets almost-empty offset", {27'd0, flg}, {27'd0, 5'b01010});
    pop_n(6, "R9 no data stored during load");
    settle();

    // R8/R12: reset restores defaults and clears contents
    push_n(4);
    do_reset();
    chk("R12 flags after reset with data", {27'd0, flg}, {27'd0, 5'b11000});
    push_n(7);
    settle();
    chk("R8 default ae offset, count 7", {31'd0, almost_empty}, 32'd1);
    push_n(1);
    settle();
    chk("R8 default ae offset, count 8", {31'd0, almost_empty}, 32'd0);
    push_n(240);
    settle();
    chk("R8 default af offset, count 248", {31'd0, almost_full}, 32'd0);
    push_n(1);
    settle();
    chk("R8 default af offset, count 249", {31'd0, almost_full}, 32'd1);
    pop_n(249, "R1 drain after defaults");
    settle();

    // R11: unrelated read clock
    rst = 1'b1;
    sel_async = 1'b1;
    do_reset();
    chk("R11 R12 flags after reset", {27'd0, flg}, {27'd0, 5'b11000});
    run_table("R11 async");
    overflow_test("R11 async");

    done = 1;
    finish_run();
  end
endmodule